// File: doc/BRIEF.md
# Two-Bit Mealy Analysis State Machine

This block is a small clocked sequential circuit built from two state flip-flops, named A and B, one serial input and one Mealy output. The next state and the output come from a fixed pair of next-state equations and one output equation. It is not a generic counter or detector. The present state is brought out on two ports so that its evolution can be observed cycle by cycle.

The reset input is active low and clears both flip-flops at once, without waiting for a clock. Its release passes through a two-stage synchroniser. The state therefore starts to follow the equations only on the third rising clock edge after the reset input goes high. The output is combinational, formed from the registered state and the live serial input.

Top module: `mealy_ab_fsm`

## Requirements
- R1: While `rst_n` is 0, `state_a` and `state_b` are 0 at once, with no clock edge needed.
- R2: On each rising clock edge in normal operation, A takes the value (A AND x) OR (B AND x), with A and B taken before the edge.
- R3: On each rising clock edge in normal operation, B takes the value (NOT A) AND x, with A taken before the edge.
- R4: `y_out` equals (A OR B) AND (NOT x) at all times, and follows a change of `x_in` without waiting for a clock edge.
- R5: With `x_in` = 0, every state (AB = 00, 01, 10, 11) moves to 00 at the next edge. `y_out` is 1 in states 01, 10 and 11, and 0 in state 00.
- R6: With `x_in` = 1, state 00 goes to 01, 01 goes to 11, 10 stays at 10, and 11 goes to 10. `y_out` is 0 in all four cases.
- R7: The state changes only on a rising clock edge. It stays stable between edges whatever `x_in` does.
- R8: After `rst_n` rises, the first two rising edges leave the state at 00 whatever `x_in` is. The third edge is the first to apply R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst_n | input | 1 | Active-low reset; takes effect at once, and its release is synchronised |
| x_in | input | 1 | Serial input x |
| y_out | output | 1 | Mealy output y |
| state_a | output | 1 | Present value of flip-flop A |
| state_b | output | 1 | Present value of flip-flop B |

## Verification
The bench builds the block with its default values: a two-stage reset synchroniser and a two-bit state. With these values it can reach all four states under both input values. It can also count the exact edge on which the state starts to follow the equations after reset release. Directed walks drive each state under x = 0 and x = 1. A long pseudo-random stream is compared against a reference model of the equations. Separate scenarios cover a reset applied in the middle of a cycle and changes of x between clock edges.

// File: rtl/mealy_ab_pkg.sv
package mealy_ab_pkg;
  localparam int STATE_W   = 2;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic a;
    logic b;
  } ab_state_t;

  localparam ab_state_t ST_IDLE = '{a: 1'b0, b: 1'b0};
endpackage

// File: rtl/mealy_rst_sync.sv
module mealy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

  // R8: release of the synchronised reset lags the raw release
  assert_sync_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q[0] |=> !rst_sync_n);
endmodule

// File: rtl/mealy_next_state.sv
module mealy_next_state
  import mealy_ab_pkg::*;
(
  input  ab_state_t cur,
  input  logic      x,
  output ab_state_t nxt
);
  always_comb begin
    nxt.a = (cur.a & x) | (cur.b & x);
    nxt.b = ~cur.a & x;
  end
endmodule

// File: rtl/mealy_out.sv
module mealy_out
  import mealy_ab_pkg::*;
(
  input  ab_state_t cur,
  input  logic      x,
  output logic      y
);
  always_comb begin
    y = (cur.a | cur.b) & ~x;
  end
endmodule

// File: rtl/mealy_ab_fsm.sv
module mealy_ab_fsm
  import mealy_ab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  output logic y_out,
  output logic state_a,
  output logic state_b
);
  logic      rst_int_n;
  ab_state_t st_q;
  ab_state_t st_d;

  mealy_rst_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mealy_next_state u_next (
    .cur (st_q),
    .x   (x_in),
    .nxt (st_d)
  );

  mealy_out u_out (
    .cur (st_q),
    .x   (x_in),
    .y   (y_out)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  assign state_a = st_q.a;
  assign state_b = st_q.b;

  assert_next_a_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n |=> state_a == (($past(state_a) | $past(state_b)) & $past(x_in)));

  assert_next_b_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n |=> state_b == (!$past(state_a) && $past(x_in)));

  assert_out_eq_R4: assert property (@(negedge clk) disable iff (!rst_int_n)
    y_out == ((state_a | state_b) & ~x_in));

  assert_zero_input_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !x_in |=> (!state_a && !state_b));

  assert_one_input_quiet_R6: assert property (@(negedge clk) disable iff (!rst_int_n)
    x_in |-> !y_out);
endmodule

// File: tb/mealy_ab_fsm_tb_top.sv
`timescale 1ns/1ps
module mealy_ab_fsm_tb_top;
  logic clk;
  logic rst_n;
  logic x_in;
  logic y_out;
  logic state_a;
  logic state_b;

  int n_chk;
  int n_bad;
  logic ma;
  logic mb;
  logic [15:0] lfsr;

  mealy_ab_fsm dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_in    (x_in),
    .y_out   (y_out),
    .state_a (state_a),
    .state_b (state_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one cycle: drive x at the falling edge, check y, clock, check state
  task automatic step(input logic xv, input string req);
    logic ey;
    logic na;
    logic nb;
    @(negedge clk);
    x_in = xv;
    #2;
    ey = (ma | mb) & ~xv;
    check(req, "y_out", {1'b0, y_out}, {1'b0, ey});
    na = (ma & xv) | (mb & xv);
    nb = ~ma & xv;
    @(posedge clk);
    #2;
    ma = na;
    mb = nb;
    check(req, "state AB", {state_a, state_b}, {ma, mb});
  endtask

  // full reset with synchronised release, leaves model at 00
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x_in  = 1'b0;
    #2;
    check("R1", "state in reset", {state_a, state_b}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    ma = 1'b0;
    mb = 1'b0;
  endtask

  task automatic goto_state(input logic [1:0] s);
    do_reset();
    case (s)
      2'b01: step(1'b1, "R6");
      2'b11: begin step(1'b1, "R6"); step(1'b1, "R6"); end
      2'b10: begin step(1'b1, "R6"); step(1'b1, "R6"); step(1'b1, "R6"); end
      default: ;
    endcase
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    x_in  = 1'b1;
    #3;
    check("R1", "state at start", {state_a, state_b}, 2'b00);
    check("R1", "y at start with x=1", {1'b0, y_out}, 2'b00);
  endtask

  task automatic t_sync_release();
    @(negedge clk);
    x_in  = 1'b1;
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R8", "edge 1 after release", {state_a, state_b}, 2'b00);
    @(posedge clk); #2;
    check("R8", "edge 2 after release", {state_a, state_b}, 2'b00);
    @(posedge clk); #2;
    check("R8", "edge 3 after release", {state_a, state_b}, 2'b01);
  endtask

  task automatic t_zero_input();
    for (int s = 0; s < 4; s++) begin
      goto_state(s[1:0]);
      check("R5", "reached state", {state_a, state_b}, s[1:0]);
      step(1'b0, "R5");
      check("R5", "x=0 lands in 00", {state_a, state_b}, 2'b00);
    end
  endtask

  task automatic t_one_input();
    for (int s = 0; s < 4; s++) begin
      goto_state(s[1:0]);
      step(1'b1, "R6");
    end
    goto_state(2'b10);
    step(1'b1, "R6");
    check("R6", "10 holds under x=1", {state_a, state_b}, 2'b10);
  endtask

  task automatic t_between_edges();
    goto_state(2'b01);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      x_in = k[0];
      #1;
      check("R4", "y follows x between edges", {1'b0, y_out}, {1'b0, ~k[0]});
      check("R7", "state stable between edges", {state_a, state_b}, 2'b01);
    end
    x_in = 1'b0;
    @(posedge clk); #2;
    ma = 1'b0; mb = 1'b0;
    check("R7", "state after edge", {state_a, state_b}, 2'b00);
  endtask

  task automatic t_async_mid();
    goto_state(2'b11);
    @(negedge clk);
    x_in = 1'b1;
    #3;
    rst_n = 1'b0;
    #2;
    check("R1", "cleared without edge", {state_a, state_b}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    ma = 1'b0; mb = 1'b0;
  endtask

  task automatic t_random();
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], (i % 2 == 0) ? "R2" : "R3");
    end
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    ma = 1'b0;
    mb = 1'b0;
    t_reset_state();
    t_sync_release();
    t_zero_input();
    t_one_input();
    t_between_edges();
    t_async_mid();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule